// File: doc/BRIEF.md
# Nonvolatile Memory Command Sequencer

This block sits between the system bus and a nonvolatile memory controller. Software issues a command in three steps, one write per step. First it writes one word into the memory address space, which captures the address and the data. Next it writes an operation code to the command register. Last it writes the status register with the buffer-empty bit set to 1, which launches the command. Before any of this, software must write the clock-divider register once. A busy timer stands in for the memory array. It keeps the buffer-empty and complete flags low for a fixed number of cycles, and that number depends on whether the operation is a program or an erase.

Any access that breaks the three-step order sets a sticky error flag and throws away the partly entered command. The same happens when a secured debug port tries to program or page-erase, and when stop mode is entered during a running operation. While the flag is set, every access is ignored except a status write that clears it.

Top module: `fcs_seq`

## Requirements
- R1: After reset, cbuf_empty and cmd_done are 1, and acc_err and cmd_go are 0. A status read returns 0xC0. The status byte layout is: bit 7 buffer-empty, bit 6 complete, bit 4 error, all other bits 0.
- R2: An array write sets acc_err while the divider register (reg_sel 0) has never been written. A divider write records the 7-bit value, and a read of the divider register returns {written flag, value}.
- R3: Three steps launch a command: an array write, then a command write (reg_sel 1), then a status write (reg_sel 2) with bit 7 set. After the launching edge, cmd_go is high for exactly one cycle, and cmd_code, cmd_addr and cmd_data carry the captured values. cbuf_empty and cmd_done go low on the same edge.
- R4: After a launch, cbuf_empty and cmd_done stay low for exactly N cycles and then both return to 1. N is PROG_CYCLES for codes 0x05, 0x20 and 0x25, and ERASE_CYCLES for codes 0x40 and 0x41.
- R5: An array write while cbuf_empty is 0 sets acc_err.
- R6: Each of the following sets acc_err: a second array write before launch, a second command write before launch, and a command write with no array write before it.
- R7: After an array write, a write to the divider register or the status register sets acc_err, and no command launches.
- R8: Only the codes 0x05, 0x20, 0x25, 0x40 and 0x41 are accepted. Any other code written to the command register sets acc_err.
- R9: Once the code is written, a read of any register (reg_sel 0 to 2) sets acc_err, and so does a write to the divider register.
- R10: With a command pending, a status write with bit 7 at 0 sets acc_err and launches nothing.
- R11: While acc_err is 1, all array, command and launch accesses are ignored and cmd_go stays 0. A status write with bit 4 at 1 clears the flag. A status write with bit 4 at 0 leaves it set.
- R12: A violation discards the partial command. After the flag is cleared, a launch write produces no cmd_go, and a command write sets acc_err again until a new array write arrives.
- R13: If stop_req is high while an operation runs, the operation aborts. On the next edge cbuf_empty returns to 1, cmd_done stays 0 and acc_err is set. stop_req has no effect while the block is idle.
- R14: When secured=1 and acc_dbg=1, a command write of 0x20, 0x25 or 0x40 sets acc_err. Codes 0x05 and 0x41 are still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arr_wr | input | 1 | Write strobe into the memory address space |
| arr_addr | input | AW | Address of the array write |
| arr_wdata | input | DW | Data of the array write |
| reg_wr | input | 1 | Control register write strobe |
| reg_rd | input | 1 | Control register read strobe |
| reg_sel | input | 2 | Register select: 0 divider, 1 command, 2 status, 3 reserved |
| reg_wdata | input | 8 | Control register write data |
| acc_dbg | input | 1 | Access comes from the debug port |
| secured | input | 1 | Device is secured |
| stop_req | input | 1 | Entry into stop mode |
| reg_rdata | output | 8 | Registered read data |
| acc_err | output | 1 | Sticky access-error flag |
| cbuf_empty | output | 1 | Command buffer empty, no operation running |
| cmd_done | output | 1 | Last launched operation completed |
| cmd_go | output | 1 | One-cycle launch pulse |
| cmd_code | output | 8 | Launched operation code |
| cmd_addr | output | AW | Launched address |
| cmd_data | output | DW | Launched data |

## Verification
Every result is registered, so it appears just after the clock edge that samples the access. acc_err, cmd_go, reg_rdata and the launch fields all change on that edge, and cbuf_empty falls on the launching edge itself. The flags return to 1 exactly N edges later, and an abort shows up one edge after stop_req. The bench drives each access for one cycle and samples 1 ns after the edge that consumes it. It then steps one edge at a time through the busy window, so a window that is off by one cycle is caught.

// File: rtl/fcs_pkg.sv
`timescale 1ns/1ps
package fcs_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_CMD} phase_t;

  localparam logic [1:0] SEL_DIV  = 2'd0;
  localparam logic [1:0] SEL_CMD  = 2'd1;
  localparam logic [1:0] SEL_STAT = 2'd2;

  localparam int BIT_CBE  = 7;
  localparam int BIT_DONE = 6;
  localparam int BIT_ERR  = 4;
  localparam int DIV_W    = 7;

  localparam logic [7:0] OP_BLANK = 8'h05;
  localparam logic [7:0] OP_PROG  = 8'h20;
  localparam logic [7:0] OP_BURST = 8'h25;
  localparam logic [7:0] OP_PERS  = 8'h40;
  localparam logic [7:0] OP_MERS  = 8'h41;

  function automatic logic code_legal(input logic [7:0] c);
    return (c == OP_BLANK) || (c == OP_PROG) || (c == OP_BURST) ||
           (c == OP_PERS) || (c == OP_MERS);
  endfunction

  function automatic logic code_erase(input logic [7:0] c);
    return (c == OP_PERS) || (c == OP_MERS);
  endfunction

  function automatic logic code_locked(input logic [7:0] c);
    return (c == OP_PROG) || (c == OP_BURST) || (c == OP_PERS);
  endfunction
endpackage

// File: rtl/fcs_proto.sv
`timescale 1ns/1ps
module fcs_proto
  import fcs_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arr_wr,
  input  logic [AW-1:0]    arr_addr,
  input  logic [DW-1:0]    arr_wdata,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_sel,
  input  logic [7:0]       reg_wdata,
  input  logic             acc_dbg,
  input  logic             secured,
  input  logic             busy,
  input  logic             abort,
  output logic             start,
  output logic             go_q,
  output logic             err_q,
  output logic             div_set_q,
  output logic [DIV_W-1:0] div_q,
  output logic [7:0]       code_q,
  output logic [AW-1:0]    addr_q,
  output logic [DW-1:0]    data_q
);
  phase_t phase_q;
  logic   viol, take_addr, take_cmd, take_div, clr;

  always_comb begin
    viol      = 1'b0;
    take_addr = 1'b0;
    take_cmd  = 1'b0;
    take_div  = 1'b0;
    start     = 1'b0;
    clr       = 1'b0;
    if (err_q) begin
      clr = reg_wr && (reg_sel == SEL_STAT) && reg_wdata[BIT_ERR];
    end else if (arr_wr) begin
      if (!div_set_q || busy || (phase_q != PH_IDLE)) viol = 1'b1;
      else take_addr = 1'b1;
    end else if (reg_wr) begin
      case (reg_sel)
        SEL_DIV: begin
          if (phase_q != PH_IDLE) viol = 1'b1;
          else take_div = 1'b1;
        end
        SEL_CMD: begin
          if ((phase_q != PH_ADDR) || !code_legal(reg_wdata) ||
              (acc_dbg && secured && code_locked(reg_wdata))) viol = 1'b1;
          else take_cmd = 1'b1;
        end
        SEL_STAT: begin
          if (phase_q == PH_ADDR) viol = 1'b1;
          else if (phase_q == PH_CMD) begin
            if (reg_wdata[BIT_CBE]) start = 1'b1;
            else viol = 1'b1;
          end
        end
        default: ;
      endcase
    end else if (reg_rd && (phase_q == PH_CMD) && (reg_sel != 2'd3)) begin
      viol = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      err_q     <= 1'b0;
      go_q      <= 1'b0;
      div_set_q <= 1'b0;
      div_q     <= '0;
      code_q    <= '0;
      addr_q    <= '0;
      data_q    <= '0;
    end else begin
      go_q <= start;
      if (viol || abort) err_q <= 1'b1;
      else if (clr)      err_q <= 1'b0;
      if (viol || abort || start) phase_q <= PH_IDLE;
      else if (take_addr)         phase_q <= PH_ADDR;
      else if (take_cmd)          phase_q <= PH_CMD;
      if (take_addr) begin
        addr_q <= arr_addr;
        data_q <= arr_wdata;
      end
      if (take_cmd) code_q <= reg_wdata;
      if (take_div) begin
        div_q     <= reg_wdata[DIV_W-1:0];
        div_set_q <= 1'b1;
      end
    end
  end

  AST_GO_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    go_q |=> !go_q); // R3
  AST_ERR_BLOCKS_GO: assert property (@(posedge clk) disable iff (rst)
    err_q |=> !go_q); // R11
  AST_GO_LEGAL_CODE: assert property (@(posedge clk) disable iff (rst)
    go_q |-> code_legal(code_q)); // R8
endmodule

// File: rtl/fcs_timer.sv
`timescale 1ns/1ps
module fcs_timer #(
  parameter int PROG_CYCLES  = 40,
  parameter int ERASE_CYCLES = 400
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic erase,
  input  logic abort,
  output logic busy_q,
  output logic done_q
);
  localparam int MAXC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b1;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      cnt_q  <= erase ? CW'(ERASE_CYCLES - 1) : CW'(PROG_CYCLES - 1);
    end else if (abort) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  AST_COUNT_KEEPS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy_q && (cnt_q != '0) && !abort) |=> busy_q); // R4
  AST_ABORT_NOT_DONE: assert property (@(posedge clk) disable iff (rst)
    (abort && !start) |=> (!busy_q && !done_q)); // R13
endmodule

// File: rtl/fcs_seq.sv
`timescale 1ns/1ps
module fcs_seq
  import fcs_pkg::*;
#(
  parameter int AW           = 16,
  parameter int DW           = 8,
  parameter int PROG_CYCLES  = 40,
  parameter int ERASE_CYCLES = 400
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arr_wr,
  input  logic [AW-1:0] arr_addr,
  input  logic [DW-1:0] arr_wdata,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_sel,
  input  logic [7:0]    reg_wdata,
  input  logic          acc_dbg,
  input  logic          secured,
  input  logic          stop_req,
  output logic [7:0]    reg_rdata,
  output logic          acc_err,
  output logic          cbuf_empty,
  output logic          cmd_done,
  output logic          cmd_go,
  output logic [7:0]    cmd_code,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data
);
  logic             busy, done, start, abort, div_set;
  logic [DIV_W-1:0] div_val;
  logic [7:0]       stat_vec;

  assign abort = stop_req && busy;

  fcs_proto #(.AW(AW), .DW(DW)) u_proto (
    .clk(clk), .rst(rst),
    .arr_wr(arr_wr), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .acc_dbg(acc_dbg), .secured(secured), .busy(busy), .abort(abort),
    .start(start), .go_q(cmd_go), .err_q(acc_err),
    .div_set_q(div_set), .div_q(div_val),
    .code_q(cmd_code), .addr_q(cmd_addr), .data_q(cmd_data)
  );

  fcs_timer #(.PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(start), .erase(code_erase(cmd_code)),
    .abort(abort), .busy_q(busy), .done_q(done)
  );

  assign cbuf_empty = !busy;
  assign cmd_done   = done;

  always_comb begin
    stat_vec           = '0;
    stat_vec[BIT_CBE]  = !busy;
    stat_vec[BIT_DONE] = done;
    stat_vec[BIT_ERR]  = acc_err;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_sel)
        SEL_DIV:  reg_rdata <= {div_set, div_val};
        SEL_CMD:  reg_rdata <= cmd_code;
        SEL_STAT: reg_rdata <= stat_vec;
        default:  reg_rdata <= '0;
      endcase
    end
  end

  AST_GO_DROPS_BUFFER: assert property (@(posedge clk) disable iff (rst)
    cmd_go |-> (!cbuf_empty && !cmd_done)); // R3
  AST_STOP_RAISES_ERR: assert property (@(posedge clk) disable iff (rst)
    (stop_req && !cbuf_empty) |=> (acc_err && cbuf_empty)); // R13
endmodule

// File: tb/fcs_seq_test.sv
`timescale 1ns/1ps
module fcs_seq_test;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int NP = 6;
  localparam int NE = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          arr_wr = 1'b0;
  logic [AW-1:0] arr_addr = '0;
  logic [DW-1:0] arr_wdata = '0;
  logic          reg_wr = 1'b0;
  logic          reg_rd = 1'b0;
  logic [1:0]    reg_sel = '0;
  logic [7:0]    reg_wdata = '0;
  logic          acc_dbg = 1'b0;
  logic          secured = 1'b0;
  logic          stop_req = 1'b0;
  logic [7:0]    reg_rdata;
  logic          acc_err, cbuf_empty, cmd_done, cmd_go;
  logic [7:0]    cmd_code;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_data;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  fcs_seq #(.AW(AW), .DW(DW), .PROG_CYCLES(NP), .ERASE_CYCLES(NE)) uut (
    .clk(clk), .rst(rst), .arr_wr(arr_wr), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .acc_dbg(acc_dbg), .secured(secured), .stop_req(stop_req),
    .reg_rdata(reg_rdata), .acc_err(acc_err), .cbuf_empty(cbuf_empty),
    .cmd_done(cmd_done), .cmd_go(cmd_go), .cmd_code(cmd_code),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic arr_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    arr_addr = a; arr_wdata = d; arr_wr = 1'b1;
    step();
    arr_wr = 1'b0;
  endtask

  task automatic reg_write(input logic [1:0] s, input logic [7:0] d, input logic dbg);
    reg_sel = s; reg_wdata = d; acc_dbg = dbg; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0; acc_dbg = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] s);
    reg_sel = s; reg_rd = 1'b1;
    step();
    reg_rd = 1'b0;
  endtask

  task automatic clear_err(input string req);
    reg_write(2'd2, 8'h10, 1'b0);
    chk({req, " clear"}, acc_err, 1'b0);
  endtask

  task automatic launch_ok(input logic [7:0] code, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, input logic dbg, input int n);
    arr_write(a, d);
    reg_write(2'd1, code, dbg);
    chk("R3 no go before launch", cmd_go, 1'b0);
    reg_write(2'd2, 8'h80, 1'b0);
    chk("R3 go", cmd_go, 1'b1);
    chk("R3 code", cmd_code, code);
    chk("R3 addr", cmd_addr, a);
    chk("R3 data", cmd_data, d);
    chk("R3 cbe low", cbuf_empty, 1'b0);
    chk("R3 done low", cmd_done, 1'b0);
    chk("R3 err", acc_err, 1'b0);
    for (int i = 0; i < n - 1; i++) begin
      step();
      if (i == 0) chk("R3 go single", cmd_go, 1'b0);
      chk("R4 busy window", cbuf_empty, 1'b0);
    end
    step();
    chk("R4 cbe back", cbuf_empty, 1'b1);
    chk("R4 done back", cmd_done, 1'b1);
  endtask

  task automatic t_reset();
    chk("R1 cbe", cbuf_empty, 1'b1);
    chk("R1 done", cmd_done, 1'b1);
    chk("R1 err", acc_err, 1'b0);
    chk("R1 go", cmd_go, 1'b0);
    reg_read(2'd2);
    chk("R1 status read", reg_rdata, 8'hC0);
  endtask

  task automatic t_no_divider();
    arr_write(16'h1234, 8'h55);
    chk("R2 write before divider", acc_err, 1'b1);
    clear_err("R11");
    reg_write(2'd0, 8'h13, 1'b0);
    reg_read(2'd0);
    chk("R2 divider read", reg_rdata, 8'h93);
    chk("R2 err after divider", acc_err, 1'b0);
  endtask

  task automatic t_launches();
    launch_ok(8'h20, 16'hA010, 8'h3C, 1'b0, NP);
    launch_ok(8'h41, 16'hF000, 8'hFF, 1'b0, NE);
    launch_ok(8'h05, 16'h0200, 8'h00, 1'b0, NP);
    launch_ok(8'h40, 16'hE200, 8'h11, 1'b0, NE);
  endtask

  task automatic t_busy_write();
    arr_write(16'h0100, 8'h01);
    reg_write(2'd1, 8'h25, 1'b0);
    reg_write(2'd2, 8'h80, 1'b0);
    arr_write(16'h0101, 8'h02);
    chk("R5 write while busy", acc_err, 1'b1);
    idle(NP);
    clear_err("R5");
  endtask

  task automatic t_double();
    arr_write(16'h0300, 8'h01);
    arr_write(16'h0301, 8'h02);
    chk("R6 second array write", acc_err, 1'b1);
    clear_err("R6");
    arr_write(16'h0300, 8'h01);
    reg_write(2'd1, 8'h20, 1'b0);
    reg_write(2'd1, 8'h20, 1'b0);
    chk("R6 second command write", acc_err, 1'b1);
    clear_err("R6");
  endtask

  task automatic t_ctl_after_addr();
    arr_write(16'h0400, 8'h01);
    reg_write(2'd0, 8'h13, 1'b0);
    chk("R7 divider after addr", acc_err, 1'b1);
    clear_err("R7");
    arr_write(16'h0400, 8'h01);
    reg_write(2'd2, 8'h80, 1'b0);
    chk("R7 status after addr", acc_err, 1'b1);
    chk("R7 no go", cmd_go, 1'b0);
    clear_err("R7");
  endtask

  task automatic t_bad_code();
    arr_write(16'h0500, 8'h01);
    reg_write(2'd1, 8'h30, 1'b0);
    chk("R8 illegal 0x30", acc_err, 1'b1);
    clear_err("R8");
    arr_write(16'h0500, 8'h01);
    reg_write(2'd1, 8'h21, 1'b0);
    chk("R8 illegal 0x21", acc_err, 1'b1);
    clear_err("R8");
  endtask

  task automatic t_after_cmd();
    arr_write(16'h0600, 8'h01);
    reg_write(2'd1, 8'h20, 1'b0);
    reg_read(2'd2);
    chk("R9 read after cmd", acc_err, 1'b1);
    clear_err("R9");
    arr_write(16'h0600, 8'h01);
    reg_write(2'd1, 8'h20, 1'b0);
    reg_write(2'd0, 8'h13, 1'b0);
    chk("R9 divider after cmd", acc_err, 1'b1);
    clear_err("R9");
  endtask

  task automatic t_cancel();
    arr_write(16'h0700, 8'h01);
    reg_write(2'd1, 8'h20, 1'b0);
    reg_write(2'd2, 8'h00, 1'b0);
    chk("R10 cancel err", acc_err, 1'b1);
    chk("R10 no go", cmd_go, 1'b0);
    chk("R10 cbe", cbuf_empty, 1'b1);
    clear_err("R10");
  endtask

  task automatic t_sticky();
    arr_write(16'h0800, 8'h01);
    arr_write(16'h0801, 8'h01);
    reg_write(2'd2, 8'h00, 1'b0);
    chk("R11 zero write keeps err", acc_err, 1'b1);
    arr_write(16'h0802, 8'h01);
    reg_write(2'd1, 8'h20, 1'b0);
    reg_write(2'd2, 8'h80, 1'b0);
    chk("R11 no go while err", cmd_go, 1'b0);
    chk("R11 no busy while err", cbuf_empty, 1'b1);
    chk("R11 err held", acc_err, 1'b1);
    clear_err("R11");
  endtask

  task automatic t_discard();
    arr_write(16'h0900, 8'h01);
    reg_write(2'd1, 8'h20, 1'b0);
    reg_write(2'd1, 8'h20, 1'b0);
    clear_err("R12");
    reg_write(2'd2, 8'h80, 1'b0);
    chk("R12 no go after discard", cmd_go, 1'b0);
    chk("R12 no err on idle launch", acc_err, 1'b0);
    reg_write(2'd1, 8'h20, 1'b0);
    chk("R12 cmd without addr", acc_err, 1'b1);
    clear_err("R12");
  endtask

  task automatic t_stop();
    stop_req = 1'b1;
    step();
    stop_req = 1'b0;
    chk("R13 stop idle no err", acc_err, 1'b0);
    arr_write(16'hC000, 8'h01);
    reg_write(2'd1, 8'h40, 1'b0);
    reg_write(2'd2, 8'h80, 1'b0);
    idle(2);
    stop_req = 1'b1;
    step();
    stop_req = 1'b0;
    chk("R13 abort cbe", cbuf_empty, 1'b1);
    chk("R13 abort done", cmd_done, 1'b0);
    chk("R13 abort err", acc_err, 1'b1);
    clear_err("R13");
  endtask

  task automatic t_secure();
    secured = 1'b1;
    arr_write(16'h0A00, 8'h01);
    reg_write(2'd1, 8'h25, 1'b1);
    chk("R14 secured debug 0x25", acc_err, 1'b1);
    clear_err("R14");
    arr_write(16'h0A00, 8'h01);
    reg_write(2'd1, 8'h40, 1'b1);
    chk("R14 secured debug 0x40", acc_err, 1'b1);
    clear_err("R14");
    launch_ok(8'h41, 16'h0A00, 8'h77, 1'b1, NE);
    chk("R14 mass erase allowed", acc_err, 1'b0);
    launch_ok(8'h20, 16'h0A01, 8'h78, 1'b0, NP);
    chk("R14 non-debug program allowed", acc_err, 1'b0);
    secured = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    t_reset();
    t_no_divider();
    t_launches();
    t_busy_write();
    t_double();
    t_ctl_after_addr();
    t_bad_code();
    t_after_cmd();
    t_cancel();
    t_sticky();
    t_discard();
    t_stop();
    t_secure();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule